// File: doc/BRIEF.md
# Debug Trace Operand Nibble Serializer

This block turns bus-transfer operands and taken-branch target addresses into a narrow trace stream. An accepted event raises a 4-bit status marker for one cycle. The selected bytes of the value then leave a 4-bit data port, one nibble per clock, least-significant nibble first. While a stream is in progress the block reports busy and drops any new event.

A 5-bit configuration word sets the behaviour. Bits [1:0] select which bus directions have their operands captured. Bits [3:2] select how many low bytes of a branch target are emitted. Bit 4 blocks writes from the processor. The word has two write ports. The processor port can be locked out. The external debugger port can always write, and it is the only port that can change the lock bit.

Top module: `trace_nibble_ser`

## Requirements
- R1: Configuration bits [1:0] set the capture mode. 00 captures nothing, 01 captures writes only, 10 captures reads only, 11 captures both. A transfer that is not captured still shows its marker but emits no nibbles.
- R2: A captured operand emits 2 nibbles for size code 0 (byte), 4 for code 1 (word) and 8 for codes 2 and 3 (long). These nibbles come from the low bits of the data value.
- R3: Nibbles appear one per clock on the cycles directly after the marker cycle, least-significant nibble first.
- R4: Configuration bits [3:2] set the branch-target length. 00, 01, 10 and 11 give 0, 4, 6 and 8 nibbles of the target address.
- R5: The marker appears on the cycle after the accepting clock edge, and the data port reads 0 on that cycle. Marker values: 5 for a taken branch, 8 for a byte/word write, 9 for a long write, 10 for a byte/word read, 11 for a long read. The marker is 0 on all other cycles.
- R6: Busy is high on every output cycle that still has a nibble to follow. An event presented while busy is high is dropped. An event presented on the last-nibble cycle is accepted.
- R7: The data port reads 0 on every cycle that does not carry a nibble.
- R8: While bit 4 (inhibit) is set, every processor write to the configuration word is ignored.
- R9: Only the debugger port changes the inhibit bit. A permitted processor write updates bits [3:0] only. When both ports write in the same cycle, the debugger value wins.
- R10: Reset clears the configuration word, the marker, the data port and busy.
- R11: When a branch and a transfer are presented in the same accepting cycle, the branch is taken and the transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor configuration write strobe |
| cpu_wr_data | input | 5 | Processor configuration write value |
| dbg_wr_en | input | 1 | Debugger configuration write strobe |
| dbg_wr_data | input | 5 | Debugger configuration write value |
| xfer_vld | input | 1 | Bus transfer strobe |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 2 | 0 byte, 1 word, 2/3 long |
| xfer_data | input | DATA_W | Transfer operand |
| br_vld | input | 1 | Taken-branch strobe |
| br_target | input | DATA_W | Branch target address |
| trc_data | output | NIB_W | Trace data nibble |
| trc_mark | output | 4 | Status marker |
| trc_busy | output | 1 | Stream in progress |

## Verification
The hardest cases to reach from the ports are the boundaries of the busy window. One is an event that lands in the last busy cycle, which must be dropped. The other is an event on the last-nibble cycle, which must be taken. The stimulus injects a branch and a transfer at chosen offsets inside long streams, and it issues transfers back to back so that each new one meets the previous stream's last nibble. A second difficult case is the inhibit lock, which is only visible through later captures. The stimulus therefore follows each blocked or permitted processor write with a transfer whose capture outcome shows which configuration took effect.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef struct packed {
    logic       inhibit;
    logic [1:0] br_bytes;
    logic [1:0] cap_mode;
  } cfg_t;

  localparam int CFG_W = 5;

  localparam logic [3:0] MK_NONE    = 4'd0;
  localparam logic [3:0] MK_BRANCH  = 4'd5;
  localparam logic [3:0] MK_WR_SHORT = 4'd8;
  localparam logic [3:0] MK_WR_LONG  = 4'd9;
  localparam logic [3:0] MK_RD_SHORT = 4'd10;
  localparam logic [3:0] MK_RD_LONG  = 4'd11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr_en,
  input  logic [CFG_W-1:0] cpu_wr_data,
  input  logic             dbg_wr_en,
  input  logic [CFG_W-1:0] dbg_wr_data,
  output cfg_t             cfg_q
);
  cfg_t cpu_v;
  assign cpu_v = cfg_t'(cpu_wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (dbg_wr_en) begin
      cfg_q <= cfg_t'(dbg_wr_data);
    end else if (cpu_wr_en && !cfg_q.inhibit) begin
      cfg_q.cap_mode <= cpu_v.cap_mode;
      cfg_q.br_bytes <= cpu_v.br_bytes;
    end
  end
endmodule

// File: rtl/trc_event_sel.sv
module trc_event_sel
  import trc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  localparam int NIB_N = DATA_W / NIB_W,
  localparam int CNT_W = $clog2(NIB_N + 1)
) (
  input  cfg_t              cfg,
  input  logic              idle,
  input  logic              xfer_vld,
  input  logic              xfer_wr,
  input  logic [1:0]        xfer_size,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              br_vld,
  input  logic [DATA_W-1:0] br_target,
  output logic              take,
  output logic [3:0]        marker,
  output logic [CNT_W-1:0]  nib_cnt,
  output logic [DATA_W-1:0] payload
);
  localparam int NPB = 8 / NIB_W;

  logic             capture;
  logic             is_long;
  logic [CNT_W-1:0] br_cnt;
  logic [CNT_W-1:0] op_cnt;

  assign is_long = (xfer_size != SZ_BYTE) && (xfer_size != SZ_WORD);
  assign capture = xfer_wr ? cfg.cap_mode[0] : cfg.cap_mode[1];

  always_comb begin
    case (cfg.br_bytes)
      2'd0:    br_cnt = '0;
      2'd1:    br_cnt = CNT_W'(2 * NPB);
      2'd2:    br_cnt = CNT_W'(3 * NPB);
      default: br_cnt = CNT_W'(NIB_N);
    endcase
    case (xfer_size)
      SZ_BYTE: op_cnt = CNT_W'(NPB);
      SZ_WORD: op_cnt = CNT_W'(2 * NPB);
      default: op_cnt = CNT_W'(NIB_N);
    endcase
  end

  always_comb begin
    take    = 1'b0;
    marker  = MK_NONE;
    nib_cnt = '0;
    payload = '0;
    if (idle && br_vld) begin
      take    = 1'b1;
      marker  = MK_BRANCH;
      nib_cnt = br_cnt;
      payload = br_target;
    end else if (idle && xfer_vld) begin
      take    = 1'b1;
      marker  = xfer_wr ? (is_long ? MK_WR_LONG : MK_WR_SHORT)
                        : (is_long ? MK_RD_LONG : MK_RD_SHORT);
      nib_cnt = capture ? op_cnt : '0;
      payload = xfer_data;
    end
  end
endmodule

// File: rtl/trc_nibble_shift.sv
module trc_nibble_shift #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  localparam int NIB_N = DATA_W / NIB_W,
  localparam int CNT_W = $clog2(NIB_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [3:0]        marker,
  input  logic [CNT_W-1:0]  nib_cnt,
  input  logic [DATA_W-1:0] payload,
  output logic [NIB_W-1:0]  nib_q,
  output logic [3:0]        mark_q,
  output logic              busy
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  rem_q;

  assign busy = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rem_q  <= '0;
      nib_q  <= '0;
      mark_q <= '0;
    end else begin
      mark_q <= load ? marker : 4'd0;
      if (load) begin
        sh_q  <= payload;
        rem_q <= nib_cnt;
        nib_q <= '0;
      end else if (rem_q != '0) begin
        nib_q <= sh_q[NIB_W-1:0];
        sh_q  <= sh_q >> NIB_W;
        rem_q <= rem_q - 1'b1;
      end else begin
        nib_q <= '0;
      end
    end
  end
endmodule

// File: rtl/trace_nibble_ser.sv
module trace_nibble_ser
  import trc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [4:0]        cpu_wr_data,
  input  logic              dbg_wr_en,
  input  logic [4:0]        dbg_wr_data,
  input  logic              xfer_vld,
  input  logic              xfer_wr,
  input  logic [1:0]        xfer_size,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              br_vld,
  input  logic [DATA_W-1:0] br_target,
  output logic [NIB_W-1:0]  trc_data,
  output logic [3:0]        trc_mark,
  output logic              trc_busy
);
  localparam int NIB_N = DATA_W / NIB_W;
  localparam int CNT_W = $clog2(NIB_N + 1);

  cfg_t              cfg_q;
  logic [CFG_W-1:0]  cfg_word;
  logic              take;
  logic [3:0]        marker;
  logic [CNT_W-1:0]  nib_cnt;
  logic [DATA_W-1:0] payload;
  logic              busy;

  assign cfg_word = cfg_q;
  assign trc_busy = busy;

  trc_cfg_reg u_cfg (
    .clk(clk), .rst(rst),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
    .cfg_q(cfg_q)
  );

  trc_event_sel #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_sel (
    .cfg(cfg_q), .idle(!busy),
    .xfer_vld(xfer_vld), .xfer_wr(xfer_wr), .xfer_size(xfer_size),
    .xfer_data(xfer_data), .br_vld(br_vld), .br_target(br_target),
    .take(take), .marker(marker), .nib_cnt(nib_cnt), .payload(payload)
  );

  trc_nibble_shift #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst(rst), .load(take), .marker(marker),
    .nib_cnt(nib_cnt), .payload(payload),
    .nib_q(trc_data), .mark_q(trc_mark), .busy(busy)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NIB_W-1:0] trc_data,
  input logic [3:0]       trc_mark,
  input logic             trc_busy,
  input logic             dbg_wr_en,
  input logic [4:0]       cfg_word
);
  // R5: a marker cycle never carries data
  a_r5_marker_no_data: assert property (@(posedge clk) disable iff (rst)
    (trc_mark != 4'd0) |-> (trc_data == '0));

  // R5: only the defined marker codes appear
  a_r5_marker_legal: assert property (@(posedge clk) disable iff (rst)
    (trc_mark == 4'd0) || (trc_mark == 4'd5) || (trc_mark == 4'd8) ||
    (trc_mark == 4'd9) || (trc_mark == 4'd10) || (trc_mark == 4'd11));

  // R6: no event is accepted while busy
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    trc_busy |=> (trc_mark == 4'd0));

  // R7: the cycle after a non-busy cycle carries no nibble
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !trc_busy |=> (trc_data == '0));

  // R8: locked configuration changes only through the debugger port
  a_r8_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_word[4]) && !$past(dbg_wr_en)) |-> (cfg_word == $past(cfg_word)));

  // R9: inhibit bit moves only on a debugger write
  a_r9_inhibit_dbg_only: assert property (@(posedge clk) disable iff (rst)
    !$past(dbg_wr_en) |-> (cfg_word[4] == $past(cfg_word[4])));
endmodule

bind trace_nibble_ser trc_checker #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .trc_data(trc_data), .trc_mark(trc_mark),
  .trc_busy(trc_busy), .dbg_wr_en(dbg_wr_en), .cfg_word(cfg_word)
);

// File: tb/trace_nibble_ser_bench.sv
module trace_nibble_ser_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 0, dbg_wr_en = 0;
  logic [4:0]  cpu_wr_data = 0, dbg_wr_data = 0;
  logic        xfer_vld = 0, xfer_wr = 0, br_vld = 0;
  logic [1:0]  xfer_size = 0;
  logic [31:0] xfer_data = 0, br_target = 0;
  logic [3:0]  trc_data, trc_mark;
  logic        trc_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] mk;
    logic [3:0] dd;
    logic       bz;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  trace_nibble_ser u_trace_nibble_ser (
    .clk(clk), .rst(rst),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
    .xfer_vld(xfer_vld), .xfer_wr(xfer_wr), .xfer_size(xfer_size),
    .xfer_data(xfer_data), .br_vld(br_vld), .br_target(br_target),
    .trc_data(trc_data), .trc_mark(trc_mark), .trc_busy(trc_busy)
  );

  // monitor: compare each cycle against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (trc_mark !== it.mk || trc_data !== it.dd || trc_busy !== it.bz) begin
          n_bad++;
          $display("FAIL %s: mark/data/busy actual %0d/%0h/%0b expected %0d/%0h/%0b",
                   it.tag, trc_mark, trc_data, trc_busy, it.mk, it.dd, it.bz);
        end
      end
    end
  end

  task automatic cyc(input logic [3:0] mk, input logic [3:0] dd, input logic bz,
                     input string tag);
    item_t it;
    it.mk = mk; it.dd = dd; it.bz = bz; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    cpu_wr_en = 0; dbg_wr_en = 0; xfer_vld = 0; br_vld = 0;
  endtask

  function automatic int nib_sz(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  function automatic int nib_bb(input logic [1:0] b);
    return (b == 2'd0) ? 0 : (b == 2'd1) ? 4 : (b == 2'd2) ? 6 : 8;
  endfunction

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(4'd0, 4'd0, 1'b0, tag);
  endtask

  task automatic cpu_wr(input logic [4:0] v, input string tag);
    cpu_wr_en = 1; cpu_wr_data = v;
    cyc(4'd0, 4'd0, 1'b0, tag);
  endtask

  task automatic dbg_wr(input logic [4:0] v, input string tag);
    dbg_wr_en = 1; dbg_wr_data = v;
    cyc(4'd0, 4'd0, 1'b0, tag);
  endtask

  // inj: cycle index (1..n) at which a competing event is presented, 0 = none
  task automatic do_xfer(input logic wr, input logic [1:0] sz, input logic [31:0] d,
                         input bit cap, input int inj, input string tag);
    int n;
    logic [3:0] mk;
    n  = cap ? nib_sz(sz) : 0;
    mk = wr ? ((sz >= 2) ? 4'd9 : 4'd8) : ((sz >= 2) ? 4'd11 : 4'd10);
    xfer_vld = 1; xfer_wr = wr; xfer_size = sz; xfer_data = d;
    cyc(mk, 4'd0, n > 0, tag);
    for (int i = 1; i <= n; i++) begin
      if (i == inj) begin
        br_vld = 1; br_target = 32'hFFFF_FFFF;
        xfer_vld = 1; xfer_wr = 1; xfer_size = 2; xfer_data = 32'hFFFF_FFFF;
      end
      cyc(4'd0, d[4*(i-1) +: 4], i < n, tag);
    end
  endtask

  task automatic do_br(input logic [31:0] t, input logic [1:0] bb, input bit with_xfer,
                       input string tag);
    int n;
    n = nib_bb(bb);
    br_vld = 1; br_target = t;
    if (with_xfer) begin
      xfer_vld = 1; xfer_wr = 0; xfer_size = 2; xfer_data = 32'h5555_5555;
    end
    cyc(4'd5, 4'd0, n > 0, tag);
    for (int i = 1; i <= n; i++) cyc(4'd0, t[4*(i-1) +: 4], i < n, tag);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (trc_mark !== 4'd0 || trc_data !== 4'd0 || trc_busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: mark/data/busy actual %0d/%0h/%0b expected 0/0/0",
               trc_mark, trc_data, trc_busy);
    end
    rst = 0;
    idle(2, "R10");
    // R10/R1: config cleared -> mode 00, marker only
    do_xfer(1, 2, 32'h1234_5678, 0, 0, "R10 mode00");
    do_br(32'hCAFE_BABE, 2'd0, 0, "R10 bb00");

    // R1 mode 01, branch bytes 11
    dbg_wr(5'b0_11_01, "R1");
    do_xfer(1, 2, 32'h8765_4321, 1, 0, "R1 wr long");
    do_xfer(0, 1, 32'h0000_BEEF, 0, 0, "R1 rd dropped");
    do_xfer(1, 0, 32'hFFFF_FFA5, 1, 0, "R2 byte");
    do_xfer(1, 3, 32'h0F1E_2D3C, 1, 0, "R2 size3 long");
    // R1 mode 10 via processor
    cpu_wr(5'b0_11_10, "R1");
    do_xfer(0, 2, 32'hA1B2_C3D4, 1, 0, "R1 rd long");
    do_xfer(1, 1, 32'h0000_1111, 0, 0, "R1 wr dropped");
    // R1 mode 11
    cpu_wr(5'b0_11_11, "R1");
    do_xfer(0, 0, 32'h0000_003C, 1, 0, "R3 rd byte");
    do_xfer(1, 1, 32'h0000_9A7B, 1, 0, "R3 wr word");

    // R4 branch lengths
    cpu_wr(5'b0_00_11, "R4");
    do_br(32'h1357_9BDF, 2'd0, 0, "R4 bb00");
    cpu_wr(5'b0_01_11, "R4");
    do_br(32'h1357_9BDF, 2'd1, 0, "R4 bb01");
    cpu_wr(5'b0_10_11, "R4");
    do_br(32'h2468_ACE0, 2'd2, 0, "R4 bb10");
    cpu_wr(5'b0_11_11, "R4");
    do_br(32'hFEDC_BA98, 2'd3, 0, "R4 bb11");

    // R6: events during busy dropped, incl. last busy cycle
    do_xfer(1, 2, 32'h7654_3210, 1, 1, "R6 inj first");
    do_xfer(0, 2, 32'h0246_8ACE, 1, 8, "R6 inj last busy");
    do_xfer(1, 1, 32'h0000_4321, 1, 3, "R6 inj word");
    // R6: back-to-back accepted on last-nibble cycle
    do_xfer(1, 0, 32'h0000_00E7, 1, 0, "R6 b2b");
    // R11: branch beats transfer
    do_br(32'h0BAD_F00D, 2'd3, 1, "R11");
    idle(1, "R7");

    // R8: inhibit
    dbg_wr(5'b1_11_11, "R8");
    cpu_wr(5'b0_00_00, "R8");
    do_xfer(1, 0, 32'h0000_005A, 1, 0, "R8 still captured");
    do_br(32'h0000_ABCD, 2'd3, 0, "R8 bb kept");
    // R9: processor cannot clear inhibit
    cpu_wr(5'b0_00_00, "R9");
    do_xfer(0, 1, 32'h0000_6C6C, 1, 0, "R9 inhibit kept");
    // R9: debugger clears it; processor cannot set it
    dbg_wr(5'b0_11_11, "R9");
    cpu_wr(5'b1_11_11, "R9");
    cpu_wr(5'b0_00_00, "R9");
    do_xfer(1, 2, 32'h1111_2222, 0, 0, "R9 cpu write took");
    // R9: simultaneous writes, debugger wins (mode 10)
    cpu_wr_en = 1; cpu_wr_data = 5'b0_00_01;
    dbg_wr_en = 1; dbg_wr_data = 5'b0_00_10;
    cyc(4'd0, 4'd0, 1'b0, "R9");
    do_xfer(1, 1, 32'h0000_3333, 0, 0, "R9 dbg wins wr");
    do_xfer(0, 1, 32'h0000_4A5B, 1, 0, "R9 dbg wins rd");
    idle(3, "R7");

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule